// File: doc/BRIEF.md
# External Clock Bypass Controller

This block decides when the chip should leave its internal oscillator and run from an external clock. It keeps a lockable select register and takes a test-enable input and a direct bypass request from lifecycle control. From these it drives a bypass request to the analog clock source. When that source acknowledges, the block speeds up two derived clocks by removing one divide-by-two stage from each of them. Scan mode blocks this change.

All control values use a 4-bit "On"/"Off" code with a large Hamming distance. "On" is 4'b1010 and "Off" is 4'b0101. Every other value is treated as "Off". The two derived dividers are modelled as clock-enable generators driven from one shared 2-bit phase counter. The divider control changes only when that counter wraps, so no shortened enable pulse can appear. The block has no streaming data path. Every pin is a plain control or status level, so no valid/ready back-pressure applies.

Top module: `extclk_bypass_ctrl`

## Requirements
- R1: After reset the select register reads 4'b0101 ("Off") and the write-enable status reads 1. The bypass request drives 4'b0101 and the step-up control is 0.
- R2: A select write strobe loads the write data into the select register on the next edge only while the write-enable status is 1. While the status is 0 the register keeps its value.
- R3: A lock strobe clears the write-enable status to 0. The status then stays 0 until reset, and the next reset sets it back to 1.
- R4: A direct lifecycle bypass input equal to 4'b1010 drives the bypass request to 4'b1010 one edge later, whatever the select register and test-enable hold.
- R5: The bypass request is registered one edge after its inputs. It is 4'b1010 when the select register and test-enable both equal 4'b1010, or when R4 applies, and 4'b0101 in every other case. It never takes any other value.
- R6: The acknowledge passes through a two-flop synchronizer. The step-up control stays 0 for at least two edges after the acknowledge becomes 4'b1010.
- R7: While scan mode equals 4'b1010, the step-up control does not rise.
- R8: The step-up control changes only on the edge where the shared phase counter wraps from 3 to 0. In normal mode this edge follows a cycle where the divide-by-4 enable was high.
- R9: In normal mode the divide-by-2 enable is high on 4 of every 8 cycles and the divide-by-4 enable on 2 of 8. When stepped up these become 8 of 8 and 4 of 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_wr_i | input | 1 | Select register write strobe |
| sel_wdata_i | input | 4 | Select register write data |
| lock_clr_i | input | 1 | Write-1-to-clear strobe for the write-enable status |
| sel_q_o | output | 4 | Current select register value |
| sel_wen_o | output | 1 | Write-enable status of the select register |
| test_en_i | input | 4 | Test-enable level from lifecycle control |
| lc_byp_req_i | input | 4 | Direct bypass request from lifecycle control |
| scan_mode_i | input | 4 | Scan mode level |
| byp_req_o | output | 4 | Bypass request to the analog clock source |
| byp_ack_i | input | 4 | Acknowledge from the analog clock source (asynchronous) |
| div_step_o | output | 1 | Divider step-up control |
| div2_en_o | output | 1 | Enable of the divide-by-2 derived clock |
| div4_en_o | output | 1 | Enable of the divide-by-4 derived clock |

## Verification
The embedded assertions check four things on every cycle. The write-enable status never comes back without a reset. A locked select register holds its value. The bypass request only ever carries one of the two legal codes. A direct lifecycle request is followed by an asserted request. They also check that the step-up control moves only on a counter wrap, never rises under scan mode, and that a stepped-up divide-by-2 enable is always high. Three behaviours are shown only by the bench's scenarios: the full request truth table over every select, test-enable and lifecycle code, the synchronizer latency, and the enable duty counts before and after the switch.

// File: rtl/extclk_pkg.sv
package extclk_pkg;
  localparam int MUBI_W = 4;
  typedef logic [MUBI_W-1:0] mubi_t;
  localparam mubi_t MUBI_ON  = 4'b1010;
  localparam mubi_t MUBI_OFF = 4'b0101;

  function automatic logic mubi_is_on(mubi_t v);
    return v == MUBI_ON;
  endfunction
endpackage

// File: rtl/extclk_sel_reg.sv
module extclk_sel_reg
  import extclk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  wr_i,
  input  mubi_t wdata_i,
  input  logic  lock_clr_i,
  output mubi_t sel_o,
  output logic  wen_o
);
  mubi_t sel_q;
  logic  wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q <= MUBI_OFF;
      wen_q <= 1'b1;
    end else begin
      if (wr_i && wen_q) sel_q <= wdata_i;
      if (lock_clr_i) wen_q <= 1'b0;
    end
  end

  assign sel_o = sel_q;
  assign wen_o = wen_q;

  // R3: once cleared, the write enable stays cleared
  p_lock_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> !wen_q);
  // R2: a locked register keeps its contents
  p_locked_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |=> $stable(sel_q));
endmodule

// File: rtl/extclk_ack_sync.sv
module extclk_ack_sync
  import extclk_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mubi_t ack_i,
  output mubi_t ack_o
);
  mubi_t stage_q [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[g] <= MUBI_OFF;
        else if (g == 0) stage_q[g] <= ack_i;
        else stage_q[g] <= stage_q[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign ack_o = stage_q[STAGES-1];
endmodule

// File: rtl/extclk_div_gen.sv
module extclk_div_gen #(
  parameter int PHASE_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_want_i,
  output logic step_o,
  output logic div2_en_o,
  output logic div4_en_o
);
  localparam logic [PHASE_W-1:0] WRAP = {PHASE_W{1'b1}};

  logic [PHASE_W-1:0] cnt_q;
  logic               step_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      step_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == WRAP) step_q <= step_want_i;
    end
  end

  always_comb begin
    if (step_q) begin
      div2_en_o = 1'b1;
      div4_en_o = cnt_q[0];
    end else begin
      div2_en_o = cnt_q[0];
      div4_en_o = (cnt_q[1:0] == 2'b11);
    end
  end

  assign step_o = step_q;

  // R8: the step control moves only on a counter wrap
  p_step_on_wrap_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(step_q) |-> $past(cnt_q) == WRAP);
  // R9: stepped-up divide-by-2 enable is always high
  p_fast_div2_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_q |-> div2_en_o);
endmodule

// File: rtl/extclk_bypass_ctrl.sv
module extclk_bypass_ctrl
  import extclk_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PHASE_W     = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sel_wr_i,
  input  logic [3:0] sel_wdata_i,
  input  logic       lock_clr_i,
  output logic [3:0] sel_q_o,
  output logic       sel_wen_o,
  input  logic [3:0] test_en_i,
  input  logic [3:0] lc_byp_req_i,
  input  logic [3:0] scan_mode_i,
  output logic [3:0] byp_req_o,
  input  logic [3:0] byp_ack_i,
  output logic       div_step_o,
  output logic       div2_en_o,
  output logic       div4_en_o
);
  mubi_t sel_val;
  mubi_t ack_sync;
  mubi_t req_q;
  logic  req_want;
  logic  step_want;

  extclk_sel_reg u_sel (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (sel_wr_i),
    .wdata_i    (sel_wdata_i),
    .lock_clr_i (lock_clr_i),
    .sel_o      (sel_val),
    .wen_o      (sel_wen_o)
  );

  assign req_want = (mubi_is_on(sel_val) && mubi_is_on(test_en_i))
                  || mubi_is_on(lc_byp_req_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= MUBI_OFF;
    else         req_q <= req_want ? MUBI_ON : MUBI_OFF;
  end

  extclk_ack_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ack_i  (byp_ack_i),
    .ack_o  (ack_sync)
  );

  assign step_want = mubi_is_on(ack_sync) && !mubi_is_on(scan_mode_i);

  extclk_div_gen #(.PHASE_W(PHASE_W)) u_div (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_want_i (step_want),
    .step_o      (div_step_o),
    .div2_en_o   (div2_en_o),
    .div4_en_o   (div4_en_o)
  );

  assign sel_q_o   = sel_val;
  assign byp_req_o = req_q;

  // R5: only legal codes leave the block
  p_req_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byp_req_o == MUBI_ON) || (byp_req_o == MUBI_OFF));
  // R4: direct lifecycle request forces the outgoing request
  p_lc_forces_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mubi_is_on(lc_byp_req_i) |=> byp_req_o == MUBI_ON);
  // R7: scan mode keeps the dividers from stepping up
  p_scan_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mubi_is_on(scan_mode_i) && !div_step_o) |=> !div_step_o);
endmodule

// File: tb/extclk_bypass_ctrl_test.sv
module extclk_bypass_ctrl_test;
  localparam logic [3:0] ON  = 4'b1010;
  localparam logic [3:0] OFF = 4'b0101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_wr = 1'b0;
  logic [3:0] sel_wdata = OFF;
  logic lock_clr = 1'b0;
  logic [3:0] test_en = OFF, lc_req = OFF, scan = OFF, ack = OFF;
  logic [3:0] sel_q, req;
  logic sel_wen, step, d2, d4;
  int total = 0, bad = 0;

  always #4 clk = ~clk;

  extclk_bypass_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_wr_i(sel_wr), .sel_wdata_i(sel_wdata),
    .lock_clr_i(lock_clr), .sel_q_o(sel_q), .sel_wen_o(sel_wen),
    .test_en_i(test_en), .lc_byp_req_i(lc_req), .scan_mode_i(scan),
    .byp_req_o(req), .byp_ack_i(ack), .div_step_o(step),
    .div2_en_o(d2), .div4_en_o(d4)
  );

  task automatic step1();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; sel_wr = 1'b0; lock_clr = 1'b0;
    #20; step1(); rst_n = 1'b1; step1();
  endtask

  task automatic count_en(int n, output int c2, output int c4);
    c2 = 0; c4 = 0;
    for (int i = 0; i < n; i++) begin
      c2 += d2; c4 += d4; step1();
    end
  endtask

  task automatic wait_step(string tag);
    logic prev4;
    bit seen;
    seen = 0;
    prev4 = d4;
    for (int i = 0; i < 8 && !seen; i++) begin
      step1();
      if (step) begin
        seen = 1;
        chk({tag, " R8 div4 high before switch"}, prev4, 1);
      end
      prev4 = d4;
    end
    chk({tag, " R6 step-up rises"}, seen, 1);
  endtask

  initial begin
    #(200000 * 8);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int c2, c4;
    do_reset();
    // R1
    chk("R1 sel reset", sel_q, OFF);
    chk("R1 wen reset", sel_wen, 1);
    chk("R1 req reset", req, OFF);
    chk("R1 step reset", step, 0);

    // R5 / R4 exhaustive truth table
    for (int s = 0; s < 16; s++) begin
      sel_wr = 1'b1; sel_wdata = 4'(s); step1(); sel_wr = 1'b0;
      chk("R2 write accepted", sel_q, s);
      for (int t = 0; t < 16; t++) begin
        for (int l = 0; l < 16; l++) begin
          test_en = 4'(t); lc_req = 4'(l);
          step1();
          if (l == 10) chk("R4 lc request", req, ((s == 10 && t == 10) || l == 10) ? ON : OFF);
          else         chk("R5 request code", req, ((s == 10 && t == 10) || l == 10) ? ON : OFF);
        end
      end
    end
    test_en = OFF; lc_req = OFF;

    // R2 / R3 lock behaviour
    lock_clr = 1'b1; step1(); lock_clr = 1'b0;
    chk("R3 wen cleared", sel_wen, 0);
    sel_wr = 1'b1; sel_wdata = ON; step1(); sel_wr = 1'b0;
    chk("R2 locked write ignored", sel_q, 4'hF);
    test_en = ON; step1(); step1();
    chk("R2 locked sel gives no request", req, OFF);
    test_en = OFF;
    for (int i = 0; i < 4; i++) step1();
    chk("R3 wen stays cleared", sel_wen, 0);
    do_reset();
    chk("R3 wen back after reset", sel_wen, 1);

    // R9 normal duty, R6 sync, R8 boundary, R9 fast duty
    count_en(8, c2, c4);
    chk("R9 normal div2 count", c2, 4);
    chk("R9 normal div4 count", c4, 2);
    ack = ON; step1();
    chk("R6 sync first edge", step, 0);
    step1();
    chk("R6 sync second edge", step, 0);
    wait_step("fast");
    count_en(8, c2, c4);
    chk("R9 fast div2 count", c2, 8);
    chk("R9 fast div4 count", c4, 4);

    // R7 scan mode blocks
    ack = OFF; do_reset();
    scan = ON; ack = ON;
    begin
      int rose;
      rose = 0;
      for (int i = 0; i < 16; i++) begin step1(); rose |= step; end
      chk("R7 scan keeps step low", rose, 0);
    end
    scan = OFF;
    wait_step("scan release");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule